// File: doc/BRIEF.md
# Coarse/Fine Center-Aligned Full-Bridge PWM Sequencer

This block produces the two gate-drive levels for the left and right legs of a full-bridge switching amplifier. A fast coarse counter divides each carrier period into `PERIOD` clock cycles. Every switching edge is placed at one of those cycles. A `FINE_W`-bit sub-cycle code is issued with the edge, and an external programmable output delay element uses that code to shift the edge within the cycle. With the default 800-cycle period, a 400 MHz counter clock gives a 500 kHz carrier. A 32-step code then gives about 78 ps per step, which is roughly 15 bits of pulse-width resolution.

The schedule is pre-computed and written by a host into an internal record memory. Each record describes one carrier period. For each leg it holds a turn-on point and a turn-off point, and each point is a pair of coarse count and fine code. Records are normally placed symmetrically about mid-period, so the pulses are center-aligned. The right-leg pulse minus the left-leg pulse is the wanted bridge duty. Once `enable` is raised, the block plays records 0 up to `last_addr` and then starts again at record 0, one record per period. The next record is fetched one cycle before the counter wraps, and it takes over exactly at the wrap.

Top module: `pwm_seq_top`

## Requirements
- R1: After reset, both leg outputs are low, both fine codes are 0 and both error flags are low.
- R2: A record is `4*(CW+FINE_W)` bits wide, with CW = clog2(PERIOD). The left leg occupies the low half and the right leg the high half. Within a leg half, the bits from low to high are: turn-on count (CW bits), turn-on code (FINE_W bits), turn-off count (CW bits), turn-off code (FINE_W bits). A record is written at `wr_addr` while `wr_en` is high.
- R3: When `enable` is first sampled high at a clock edge, record 0 governs the first period. Count 0 of that period is the cycle that follows the next edge after that.
- R4: Within a period, a leg rises at the edge that ends the cycle whose count equals its turn-on count, and it falls at the edge that ends the cycle whose count equals its turn-off count. Its high time is (turn-off − turn-on) cycles.
- R5: A leg's fine output changes to the turn-on code on its rising edge and to the turn-off code on its falling edge, and it holds that value between edges. Taking each edge time as cycle×2^FINE_W + code, the pulse width is (off_count−on_count)×2^FINE_W + off_code − on_code fine steps.
- R6: Periods are exactly `PERIOD` cycles long. The records play in address order 0, 1, …, `last_addr` and then wrap to 0.
- R7: If a leg's turn-on count is not below its turn-off count, that leg stays low for the whole period. Its error flag is high from the start of that period to its end.
- R8: If a leg's turn-off count is `PERIOD` or more, the leg falls at the period wrap and its fine code is left unchanged.
- R9: When `enable` is sampled low, both legs and both error flags are low from the next cycle on, and the fine codes keep their values. A later enable starts again at record 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Coarse counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the sequence; low forces both legs low |
| last_addr | input | AW | Address of the final record before the wrap to 0 |
| wr_en | input | 1 | Host record write strobe |
| wr_addr | input | AW | Host record write address |
| wr_data | input | RW | Host record word (layout in R2) |
| leg_l | output | 1 | Left leg drive level |
| leg_r | output | 1 | Right leg drive level |
| fine_l | output | FINE_W | Left leg sub-cycle delay code |
| fine_r | output | FINE_W | Right leg sub-cycle delay code |
| err_l | output | 1 | Left leg record is invalid this period |
| err_r | output | 1 | Right leg record is invalid this period |

## Verification
Let S be the edge at which `enable` is first seen high, and let base = S+1 edges. A turn-on at count a then appears after edge base+a+1, a turn-off at count c appears after edge base+c+1, and a forced fall at the period end appears after edge base+PERIOD. Each following period shifts all of these by PERIOD. An error flag changes at the same edges as the period boundaries, and disabling clears the outputs one edge after `enable` is seen low. The driver turns these formulas into expected edges with absolute edge numbers. The monitor samples at falling clock edges and matches each observed level change, together with its fine code and its tap-model width, against the head of that leg's queue.

// File: rtl/pwm_seq_pkg.sv
`timescale 1ns/1ps
package pwm_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_PRIME = 2'd1,
      SEQ_RUN   = 2'd2
   } seq_state_e;

   // A leg record is unusable when it would turn on at or after its turn-off.
   function automatic logic edges_bad(input int unsigned on_cnt, input int unsigned off_cnt);
      return (on_cnt >= off_cnt);
   endfunction

endpackage

// File: rtl/pwm_seq_ram.sv
`timescale 1ns/1ps
module pwm_seq_ram #(
   parameter  int DEPTH = 16,
   parameter  int RW    = 60,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [RW-1:0] wr_data,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [RW-1:0] rd_q
);

   logic [RW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (rd_en) begin
         rd_q <= mem[rd_addr];
      end
   end

endmodule

// File: rtl/pwm_seq_timebase.sv
`timescale 1ns/1ps
module pwm_seq_timebase
   import pwm_seq_pkg::*;
#(
   parameter  int PERIOD = 800,
   parameter  int DEPTH  = 16,
   localparam int CW     = $clog2(PERIOD),
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic [AW-1:0] last_addr,
   output logic [CW-1:0] cnt,
   output logic [AW-1:0] rd_addr,
   output logic          rd_en,
   output logic          load,
   output logic          run
);

   localparam logic [CW-1:0] LAST     = CW'(PERIOD - 1);
   localparam logic [CW-1:0] PRE_LAST = CW'(PERIOD - 2);

   seq_state_e    state;
   logic [AW-1:0] ptr;
   logic [AW-1:0] ptr_nxt;
   logic          wrap;

   assign ptr_nxt = (ptr >= last_addr) ? '0 : ptr + 1'b1;
   assign wrap    = (state == SEQ_RUN) && (cnt == LAST);
   assign run     = (state == SEQ_RUN);
   assign rd_addr = ptr;
   assign rd_en   = enable && ((state == SEQ_IDLE) ||
                               ((state == SEQ_RUN) && (cnt == PRE_LAST)));
   assign load    = enable && ((state == SEQ_PRIME) || wrap);

   always_ff @(posedge clk) begin
      if (!rst_n || !enable) begin
         state <= SEQ_IDLE;
         cnt   <= '0;
         ptr   <= '0;
      end else begin
         unique case (state)
            SEQ_IDLE: begin
               state <= SEQ_PRIME;
            end
            SEQ_PRIME: begin
               state <= SEQ_RUN;
               cnt   <= '0;
               ptr   <= ptr_nxt;
            end
            SEQ_RUN: begin
               if (wrap) begin
                  cnt <= '0;
                  ptr <= ptr_nxt;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pwm_seq_leg.sv
`timescale 1ns/1ps
module pwm_seq_leg
   import pwm_seq_pkg::*;
#(
   parameter  int PERIOD = 800,
   parameter  int FINE_W = 5,
   localparam int CW     = $clog2(PERIOD),
   localparam int EW     = CW + FINE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              load,
   input  logic              run,
   input  logic [CW-1:0]     cnt,
   input  logic [2*EW-1:0]   rec,
   output logic              level,
   output logic [FINE_W-1:0] fine,
   output logic              bad
);

   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   logic [CW-1:0]     on_cnt,  off_cnt;
   logic [FINE_W-1:0] on_code, off_code;
   logic [CW-1:0]     on_cnt_n, off_cnt_n;
   logic [FINE_W-1:0] on_code_n, off_code_n;
   logic              hit_on, hit_off, at_end;

   assign on_cnt_n   = rec[CW-1:0];
   assign on_code_n  = rec[EW-1:CW];
   assign off_cnt_n  = rec[EW+CW-1:EW];
   assign off_code_n = rec[2*EW-1:EW+CW];

   assign hit_off = run && !bad && level && (cnt == off_cnt);
   assign at_end  = run && (cnt == LAST);
   assign hit_on  = run && !bad && !level && (cnt == on_cnt) && !at_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         on_cnt   <= '0;
         off_cnt  <= '0;
         on_code  <= '0;
         off_code <= '0;
      end else if (load) begin
         on_cnt   <= on_cnt_n;
         off_cnt  <= off_cnt_n;
         on_code  <= on_code_n;
         off_code <= off_code_n;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level <= 1'b0;
         fine  <= '0;
         bad   <= 1'b0;
      end else if (!enable) begin
         level <= 1'b0;
         bad   <= 1'b0;
      end else begin
         if (load) begin
            bad <= edges_bad(32'(on_cnt_n), 32'(off_cnt_n));
         end
         if (hit_off) begin
            level <= 1'b0;
            fine  <= off_code;
         end else if (at_end) begin
            level <= 1'b0;
         end else if (hit_on) begin
            level <= 1'b1;
            fine  <= on_code;
         end
      end
   end

endmodule

// File: rtl/pwm_seq_top.sv
`timescale 1ns/1ps
module pwm_seq_top #(
   parameter  int PERIOD = 800,
   parameter  int FINE_W = 5,
   parameter  int DEPTH  = 16,
   localparam int CW     = $clog2(PERIOD),
   localparam int EW     = CW + FINE_W,
   localparam int RW     = 4 * EW,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [AW-1:0]     last_addr,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [RW-1:0]     wr_data,
   output logic              leg_l,
   output logic              leg_r,
   output logic [FINE_W-1:0] fine_l,
   output logic [FINE_W-1:0] fine_r,
   output logic              err_l,
   output logic              err_r
);

   localparam int NLEG = 2;

   if (PERIOD < 4) begin : g_bad_period
      $error("pwm_seq_top: PERIOD must be at least 4");
   end
   if (FINE_W < 1) begin : g_bad_fine
      $error("pwm_seq_top: FINE_W must be at least 1");
   end
   if ((DEPTH < 2) || ((1 << AW) != DEPTH)) begin : g_bad_depth
      $error("pwm_seq_top: DEPTH must be a power of two, at least 2");
   end

   logic [CW-1:0]     cnt;
   logic [AW-1:0]     rd_addr;
   logic              rd_en, load, run;
   logic [RW-1:0]     rd_q;
   logic [NLEG-1:0]   lvl_q, bad_q;
   logic [FINE_W-1:0] fine_q [NLEG];

   pwm_seq_ram #(.DEPTH(DEPTH), .RW(RW)) u_ram (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_q    (rd_q)
   );

   pwm_seq_timebase #(.PERIOD(PERIOD), .DEPTH(DEPTH)) u_tb (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .last_addr (last_addr),
      .cnt       (cnt),
      .rd_addr   (rd_addr),
      .rd_en     (rd_en),
      .load      (load),
      .run       (run)
   );

   for (genvar g = 0; g < NLEG; g++) begin : g_leg
      pwm_seq_leg #(.PERIOD(PERIOD), .FINE_W(FINE_W)) u_leg (
         .clk    (clk),
         .rst_n  (rst_n),
         .enable (enable),
         .load   (load),
         .run    (run),
         .cnt    (cnt),
         .rec    (rd_q[g*2*EW +: 2*EW]),
         .level  (lvl_q[g]),
         .fine   (fine_q[g]),
         .bad    (bad_q[g])
      );
   end

   assign leg_l  = lvl_q[0];
   assign leg_r  = lvl_q[1];
   assign fine_l = fine_q[0];
   assign fine_r = fine_q[1];
   assign err_l  = bad_q[0];
   assign err_r  = bad_q[1];

endmodule

// File: rtl/pwm_seq_chk.sv
`timescale 1ns/1ps
module pwm_seq_chk #(
   parameter  int PERIOD = 800,
   parameter  int FINE_W = 5,
   localparam int CW     = $clog2(PERIOD)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic              run,
   input logic [CW-1:0]     cnt,
   input logic              leg_l,
   input logic              leg_r,
   input logic [FINE_W-1:0] fine_l,
   input logic [FINE_W-1:0] fine_r,
   input logic              err_l,
   input logic              err_r
);

   assert_off_when_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!leg_l && !leg_r && !err_l && !err_r));

   assert_err_leg_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_l |-> !leg_l) and (err_r |-> !leg_r));

   assert_code_moves_with_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(fine_l) |-> !$stable(leg_l)) and (!$stable(fine_r) |-> !$stable(leg_r)));

   assert_count_in_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CW'(PERIOD));

   assert_low_after_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (cnt == CW'(PERIOD - 1))) |=> (!leg_l && !leg_r));

endmodule

bind pwm_seq_top pwm_seq_chk #(.PERIOD(PERIOD), .FINE_W(FINE_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .enable (enable),
   .run    (run),
   .cnt    (cnt),
   .leg_l  (leg_l),
   .leg_r  (leg_r),
   .fine_l (fine_l),
   .fine_r (fine_r),
   .err_l  (err_l),
   .err_r  (err_r)
);

// File: tb/tb_pwm_seq_top.sv
`timescale 1ns/1ps
module tb_pwm_seq_top;

   localparam int P   = 800;
   localparam int FW  = 5;
   localparam int DEP = 16;
   localparam int CW  = $clog2(P);
   localparam int EW  = CW + FW;
   localparam int RW  = 4 * EW;
   localparam int AW  = $clog2(DEP);
   localparam int STEPS = 1 << FW;

   typedef struct {
      int n;
      int lvl;
      int code;
      int width;
   } ev_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic [AW-1:0] last_addr = '0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [RW-1:0] wr_data = '0;
   logic          leg_l, leg_r, err_l, err_r;
   logic [FW-1:0] fine_l, fine_r;

   int  n = 0;
   int  total = 0;
   int  fails = 0;
   bit  done = 0;
   bit  mon_on = 0;
   ev_t q_l[$];
   ev_t q_r[$];

   // record table: [rec][leg*4 + {on_cnt, on_code, off_cnt, off_code}]
   int tbl [3][8];

   always #2.5 clk = ~clk;

   always @(posedge clk) n <= n + 1;

   pwm_seq_top #(.PERIOD(P), .FINE_W(FW), .DEPTH(DEP)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .last_addr (last_addr),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .leg_l     (leg_l),
      .leg_r     (leg_r),
      .fine_l    (fine_l),
      .fine_r    (fine_r),
      .err_l     (err_l),
      .err_r     (err_r)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [RW-1:0] mk(input int r);
      logic [RW-1:0] w;
      w = '0;
      for (int lg = 0; lg < 2; lg++) begin
         w[lg*2*EW +: CW]         = CW'(tbl[r][lg*4+0]);
         w[lg*2*EW+CW +: FW]      = FW'(tbl[r][lg*4+1]);
         w[lg*2*EW+EW +: CW]      = CW'(tbl[r][lg*4+2]);
         w[lg*2*EW+EW+CW +: FW]   = FW'(tbl[r][lg*4+3]);
      end
      return w;
   endfunction

   task automatic push(input int lg, input ev_t e);
      if (lg == 0) q_l.push_back(e);
      else         q_r.push_back(e);
   endtask

   // driver: expected edges of period p (record r) for a run started at edge start+1
   task automatic push_period(input int start, input int p, input int r);
      int base;
      ev_t e;
      base = start + 2 + p * P;
      for (int lg = 0; lg < 2; lg++) begin
         int a0, b0, a1, b1;
         a0 = tbl[r][lg*4+0]; b0 = tbl[r][lg*4+1];
         a1 = tbl[r][lg*4+2]; b1 = tbl[r][lg*4+3];
         if (a0 < a1) begin
            e.n = base + a0 + 1; e.lvl = 1; e.code = b0; e.width = -1;
            push(lg, e);
            if (a1 < P) begin
               e.n = base + a1 + 1; e.lvl = 0; e.code = b1;
               e.width = (a1 - a0) * STEPS + b1 - b0;
            end else begin
               e.n = base + P; e.lvl = 0; e.code = b0;
               e.width = (P - 1 - a0) * STEPS;
            end
            push(lg, e);
         end
      end
   endtask

   int rise_t [2];

   task automatic observe(input int lg, input int lvl, input int code, ref ev_t q[$]);
      ev_t e;
      string req;
      if (q.size() == 0) begin
         chk(1'b0, "R4", $sformatf("unexpected edge leg%0d at edge", lg), n, -1);
         return;
      end
      e = q.pop_front();
      req = (e.lvl == 1) ? "R4" : (e.width < 0 ? "R8" : "R4");
      chk(n == e.n, req, $sformatf("leg%0d edge time (lvl %0d)", lg, lvl), n, e.n);
      chk(lvl == e.lvl, req, $sformatf("leg%0d level", lg), lvl, e.lvl);
      chk(code == e.code, "R5", $sformatf("leg%0d fine code", lg), code, e.code);
      if (lvl == 1) begin
         rise_t[lg] = n * STEPS + code;
      end else if (e.width >= 0) begin
         chk((n * STEPS + code - rise_t[lg]) == e.width, "R5",
             $sformatf("leg%0d tap width", lg), n * STEPS + code - rise_t[lg], e.width);
      end
   endtask

   logic p_l = 1'b0, p_r = 1'b0;

   // monitor
   always @(negedge clk) begin
      if (mon_on) begin
         if (leg_l !== p_l) observe(0, int'(leg_l), int'(fine_l), q_l);
         if (leg_r !== p_r) observe(1, int'(leg_r), int'(fine_r), q_r);
      end
      p_l <= leg_l;
      p_r <= leg_r;
   end

   task automatic wait_edge(input int target);
      while (n < target) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", n, 0);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      int start;
      // rec0: centred pulses
      tbl[0] = '{300, 5, 500, 17, 250, 0, 550, 31};
      // rec1: narrow left, wide right
      tbl[1] = '{390, 31, 410, 2, 100, 9, 700, 12};
      // rec2: invalid left (R7), right turn-off past the period (R8)
      tbl[2] = '{400, 4, 400, 6, 0, 3, 900, 7};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(leg_l == 1'b0 && leg_r == 1'b0, "R1", "legs after reset", {leg_l, leg_r}, 0);
      chk(fine_l == '0, "R1", "fine_l after reset", fine_l, 0);
      chk(fine_r == '0, "R1", "fine_r after reset", fine_r, 0);
      chk(err_l == 1'b0 && err_r == 1'b0, "R1", "err after reset", {err_l, err_r}, 0);

      // R2: host load of the record memory
      for (int r = 0; r < 3; r++) begin
         wr_en = 1'b1; wr_addr = AW'(r); wr_data = mk(r);
         @(negedge clk);
      end
      wr_en = 1'b0;
      last_addr = AW'(2);
      @(negedge clk);
      mon_on = 1'b1;
      @(negedge clk);

      // R3/R6: periods 0..3 play records 0,1,2,0; period 4 is record 1
      start = n;
      enable = 1'b1;
      push_period(start, 0, 0);
      push_period(start, 1, 1);
      push_period(start, 2, 2);
      push_period(start, 3, 0);

      wait_edge(start + 2 + P + 100);
      chk(err_l == 1'b0, "R7", "err_l in valid period", err_l, 0);
      wait_edge(start + 2 + 2 * P + 100);
      chk(err_l == 1'b1, "R7", "err_l in invalid period", err_l, 1);
      chk(err_r == 1'b0, "R7", "err_r in valid period", err_r, 0);
      chk(leg_l == 1'b0, "R7", "left leg held low", leg_l, 0);

      // period 4 (record 1): left pulse, right rise, then disable mid-pulse
      begin
         ev_t e;
         int b4;
         b4 = start + 2 + 4 * P;
         e.width = -1;
         e.n = b4 + 390 + 1; e.lvl = 1; e.code = 31; push(0, e);
         e.n = b4 + 410 + 1; e.lvl = 0; e.code = 2;  e.width = 20 * STEPS + 2 - 31; push(0, e);
         e.width = -1;
         e.n = b4 + 100 + 1; e.lvl = 1; e.code = 9;  push(1, e);
         e.n = b4 + 451;     e.lvl = 0; e.code = 9;  push(1, e);
         wait_edge(b4 + 450);
         enable = 1'b0;
      end
      @(negedge clk);
      @(negedge clk);
      chk(leg_l == 1'b0 && leg_r == 1'b0, "R9", "legs after disable", {leg_l, leg_r}, 0);
      chk(err_l == 1'b0 && err_r == 1'b0, "R9", "err after disable", {err_l, err_r}, 0);
      chk(fine_r == FW'(9), "R9", "fine_r held after disable", fine_r, 9);
      chk(q_l.size() == 0 && q_r.size() == 0, "R6", "pending edges after run",
          q_l.size() + q_r.size(), 0);

      // R9: restart begins again at record 0; R6 single-record wrap
      repeat (5) @(negedge clk);
      last_addr = AW'(0);
      start = n;
      enable = 1'b1;
      push_period(start, 0, 0);
      push_period(start, 1, 0);
      wait_edge(start + 2 + 2 * P + 5);
      chk(q_l.size() == 0 && q_r.size() == 0, "R9", "pending edges after restart",
          q_l.size() + q_r.size(), 0);
      enable = 1'b0;
      repeat (3) @(negedge clk);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule